// File: doc/BRIEF.md
# Host-to-frame-buffer bus bridge

This block places a 64K-word by 16-bit frame buffer inside a 128 KB slice of an asynchronous, strobe-based host bus. The frame buffer is built from four memories that are each 4 bits wide. A host cycle is recognised when the address strobe is low, at least one data strobe is low, the address lies in the window and the configuration-done input is high. The bridge then gives the memory exactly one access cycle and answers with an active-low acknowledge. Writes touch only the byte lanes whose data strobes are active.

A video fetch port shares the same memory. A fetch request always takes precedence over the start of a new host cycle, and the host is simply kept waiting on its acknowledge. When configuration-done is low, the host sees an empty window: it gets no acknowledge and the memory sees no strobe. Host software depends on this. It writes a signature word near the top of the window, reads it back, and so learns both that the card is fitted and that it has been configured.

Bus inputs are taken to be synchronous to `clk`. A bus running on the same system clock meets this.

Top module: `fb_bridge`

## Requirements
- R1: After reset, `dtack_n` is 1, `mem_oe_n` is 1, `mem_we_n` is 4'hF and `vid_ack` is 0.
- R2: A host cycle whose address bits 23..17 differ from 7'b0111001 gets no acknowledge and causes no memory read or write. The window is byte addresses 0x720000 to 0x73FFFF. The memory word index is address bits 16..1.
- R3: While `cfg_done` is 0, host cycles inside the window get no acknowledge and cause no memory activity.
- R4: Suppose a clock edge samples `as_n` low, a data strobe low, an address in the window, `cfg_done` high and `vid_req` low. Then `dtack_n` goes low after the next clock edge, which is the second edge of the cycle.
- R5: On a host write, `uds_n` low writes slices 3 and 2 (data bits 15..8), and `lds_n` low writes slices 1 and 0 (bits 7..0). Lanes that are not enabled keep their stored value.
- R6: On a host read (`rw` = 1), `host_rdata` holds the addressed memory word while `dtack_n` is low.
- R7: If `vid_req` is sampled high at an edge, `vid_ack` is high in the following cycle. In that cycle `mem_addr` is `vid_addr`, the memory is read and nothing is written, and no host cycle can start at that edge.
- R8: Each acknowledged host cycle drives exactly one memory access cycle, and that cycle immediately precedes the fall of `dtack_n`.
- R9: Words written at 0x73FFEA and 0x73FFEE read back unchanged.
- R10: Once `as_n` is sampled high, `dtack_n` is high after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_done | input | 1 | Configuration-complete flag; bridge is invisible while low |
| host_addr | input | 23 | Host byte address bits 23..1 |
| as_n | input | 1 | Address strobe, active low |
| uds_n | input | 1 | Upper data strobe (bits 15..8), active low |
| lds_n | input | 1 | Lower data strobe (bits 7..0), active low |
| rw | input | 1 | 1 = read, 0 = write |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data |
| dtack_n | output | 1 | Data acknowledge, active low |
| vid_req | input | 1 | Video fetch request |
| vid_addr | input | 16 | Video fetch word address |
| vid_ack | output | 1 | High in the cycle the fetch is served |
| vid_data | output | 16 | Fetched word, valid while vid_ack is high |
| mem_addr | output | 16 | Memory word address |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 4 | Per-slice write enable, active low, bit n = bits 4n+3..4n |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data (asynchronous read) |

## Verification
Some properties are checked on every cycle. Any host-side memory strobe must follow an edge that saw `cfg_done` high and an in-window address. Slice write enables must agree with the matching data strobe. A video request must be served on the next cycle with no write. `dtack_n` may fall only right after a host memory cycle, and a high `as_n` must release it. The bench scenarios cover what needs a memory model: the exact two-edge acknowledge latency, the merged byte-lane contents, read-back of the signature words, that out-of-window writes leave the memory untouched, and that a held-off host cycle completes once video requests stop.

// File: rtl/fb_bridge.sv
module fb_bridge #(
  parameter logic [6:0] WIN_TAG = 7'h39
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_done,
  input  logic [23:1] host_addr,
  input  logic        as_n,
  input  logic        uds_n,
  input  logic        lds_n,
  input  logic        rw,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic        dtack_n,
  input  logic        vid_req,
  input  logic [15:0] vid_addr,
  output logic        vid_ack,
  output logic [15:0] vid_data,
  output logic [15:0] mem_addr,
  output logic        mem_oe_n,
  output logic [3:0]  mem_we_n,
  output logic [15:0] mem_wdata,
  input  logic [15:0] mem_rdata
);

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_HOLD} st_t;
  st_t st;
  logic [15:0] rd_q;

  wire hit     = !as_n && !(uds_n && lds_n) && cfg_done && (host_addr[23:17] == WIN_TAG);
  wire host_go = (st == S_ACC) && !as_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_IDLE;
      vid_ack <= 1'b0;
      rd_q    <= '0;
    end else begin
      vid_ack <= vid_req;
      case (st)
        S_IDLE: if (hit && !vid_req) st <= S_ACC;
        S_ACC: begin
          st <= as_n ? S_IDLE : S_HOLD;
          if (host_go && rw) rd_q <= mem_rdata;
        end
        S_HOLD: if (as_n) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end

  assign dtack_n    = (st != S_HOLD);
  assign host_rdata = rd_q;
  assign mem_addr   = vid_ack ? vid_addr : host_addr[16:1];
  assign mem_oe_n   = !(vid_ack || (host_go && rw));
  assign mem_we_n   = (host_go && !rw) ? {uds_n, uds_n, lds_n, lds_n} : 4'hF;
  assign mem_wdata  = host_wdata;
  assign vid_data   = mem_rdata;

endmodule

// File: rtl/fb_bridge_chk.sv
module fb_bridge_chk #(
  parameter logic [6:0] WIN_TAG = 7'h39
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_done,
  input logic [23:1] host_addr,
  input logic        as_n,
  input logic        uds_n,
  input logic        lds_n,
  input logic        rw,
  input logic        dtack_n,
  input logic        vid_req,
  input logic        vid_ack,
  input logic        mem_oe_n,
  input logic [3:0]  mem_we_n
);

  wire host_mem = !vid_ack && (!mem_oe_n || (mem_we_n != 4'hF));

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (dtack_n && mem_oe_n && mem_we_n == 4'hF)); // R1
  AST_WINDOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n) host_mem |-> $past(host_addr[23:17]) == WIN_TAG); // R2
  AST_CFG_GATE: assert property (@(posedge clk) disable iff (!rst_n) host_mem |-> $past(cfg_done)); // R3
  AST_UPPER_LANE: assert property (@(posedge clk) disable iff (!rst_n) (!mem_we_n[3] || !mem_we_n[2]) |-> (!uds_n && !rw)); // R5
  AST_LOWER_LANE: assert property (@(posedge clk) disable iff (!rst_n) (!mem_we_n[1] || !mem_we_n[0]) |-> (!lds_n && !rw)); // R5
  AST_VIDEO_FIRST: assert property (@(posedge clk) disable iff (!rst_n) vid_req |=> (vid_ack && !mem_oe_n && mem_we_n == 4'hF)); // R7
  AST_ACK_AFTER_MEM: assert property (@(posedge clk) disable iff (!rst_n) $fell(dtack_n) |-> $past(host_mem)); // R8
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) as_n |=> dtack_n); // R10

endmodule

bind fb_bridge fb_bridge_chk #(.WIN_TAG(WIN_TAG)) u_chk (.*);

// File: tb/test_fb_bridge.sv
module test_fb_bridge;
  logic clk = 0, rst_n = 0, cfg_done = 0;
  logic [23:1] host_addr = '0;
  logic as_n = 1, uds_n = 1, lds_n = 1, rw = 1;
  logic [15:0] host_wdata = '0, host_rdata;
  logic dtack_n, vid_req = 0, vid_ack;
  logic [15:0] vid_addr = '0, vid_data, mem_addr, mem_wdata, mem_rdata;
  logic mem_oe_n;
  logic [3:0] mem_we_n;
  int checks = 0, fails = 0, host_mem_cnt = 0;
  logic [15:0] mem [1024];

  always #2.5 clk = ~clk;

  fb_bridge i_fb_bridge (.*);

  assign mem_rdata = mem[mem_addr[9:0]];
  always @(posedge clk) begin
    for (int s = 0; s < 4; s++)
      if (!mem_we_n[s]) mem[mem_addr[9:0]][4*s +: 4] <= mem_wdata[4*s +: 4];
    if (rst_n && !vid_ack && (!mem_oe_n || mem_we_n != 4'hF)) host_mem_cnt <= host_mem_cnt + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic host_cycle(input logic [23:0] a, input bit rd, input bit u, input bit l,
                            input logic [15:0] wd, output int lat, output logic [15:0] rdv);
    @(negedge clk);
    host_addr = a[23:1]; rw = rd; uds_n = !u; lds_n = !l; host_wdata = wd; as_n = 0;
    lat = -1; rdv = 'x;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      if (!dtack_n) begin lat = i; rdv = host_rdata; break; end
    end
    as_n = 1; uds_n = 1; lds_n = 1;
    @(negedge clk);
    if (lat > 0) check("R10 release", dtack_n, 1);
  endtask

  task automatic t_reset();
    check("R1 dtack", dtack_n, 1);
    check("R1 oe", mem_oe_n, 1);
    check("R1 we", mem_we_n, 4'hF);
    check("R1 vid_ack", vid_ack, 0);
  endtask

  task automatic t_unconfigured();
    int lat, c0; logic [15:0] r;
    cfg_done = 0; c0 = host_mem_cnt;
    host_cycle(24'h720010, 0, 1, 1, 16'hDEAD, lat, r);
    check("R3 no ack", lat, -1);
    check("R3 no mem", host_mem_cnt - c0, 0);
  endtask

  task automatic t_word_rw();
    int lat, c0; logic [15:0] r;
    cfg_done = 1; c0 = host_mem_cnt;
    host_cycle(24'h720010, 0, 1, 1, 16'hA5C3, lat, r);
    check("R4 write latency", lat, 2);
    check("R8 one mem cycle", host_mem_cnt - c0, 1);
    host_cycle(24'h720010, 1, 1, 1, 16'h0, lat, r);
    check("R4 read latency", lat, 2);
    check("R6 read data", r, 16'hA5C3);
  endtask

  task automatic t_lanes();
    int lat; logic [15:0] r;
    host_cycle(24'h720020, 0, 1, 1, 16'h1234, lat, r);
    host_cycle(24'h720020, 0, 1, 0, 16'hFFFF, lat, r);
    host_cycle(24'h720020, 1, 1, 1, 16'h0, lat, r);
    check("R5 upper lane", r, 16'hFF34);
    host_cycle(24'h720020, 0, 0, 1, 16'h0000, lat, r);
    host_cycle(24'h720020, 1, 0, 1, 16'h0, lat, r);
    check("R5 lower lane", r, 16'hFF00);
  endtask

  task automatic t_outside();
    int lat, c0; logic [15:0] r;
    host_cycle(24'h720200, 0, 1, 1, 16'h7777, lat, r);
    c0 = host_mem_cnt;
    host_cycle(24'h740200, 0, 1, 1, 16'h0001, lat, r);
    check("R2 no ack above", lat, -1);
    host_cycle(24'h71FFFE, 1, 1, 1, 16'h0, lat, r);
    check("R2 no ack below", lat, -1);
    check("R2 no mem", host_mem_cnt - c0, 0);
    host_cycle(24'h720200, 1, 1, 1, 16'h0, lat, r);
    check("R2 memory untouched", r, 16'h7777);
  endtask

  task automatic t_signature();
    int lat; logic [15:0] r;
    host_cycle(24'h73FFEA, 0, 1, 1, 16'hBEC5, lat, r);
    host_cycle(24'h73FFEE, 0, 1, 1, 16'h0003, lat, r);
    host_cycle(24'h73FFEA, 1, 1, 1, 16'h0, lat, r);
    check("R9 signature", r, 16'hBEC5);
    host_cycle(24'h73FFEE, 1, 1, 1, 16'h0, lat, r);
    check("R9 id word", r, 16'h0003);
  endtask

  task automatic t_video();
    @(negedge clk);
    vid_addr = 16'h0008; vid_req = 1;
    host_addr = 23'h390010; rw = 1; uds_n = 0; lds_n = 0; as_n = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R7 vid_ack", vid_ack, 1);
      check("R7 vid_data", vid_data, 16'hA5C3);
      check("R7 host held", dtack_n, 1);
    end
    vid_req = 0;
    @(negedge clk);
    check("R7 ack after release", dtack_n, 1);
    check("R7 vid_ack drop", vid_ack, 0);
    @(negedge clk);
    check("R4 ack after hold-off", dtack_n, 0);
    check("R6 read after hold-off", host_rdata, 16'hFF00);
    as_n = 1; uds_n = 1; lds_n = 1;
    @(negedge clk);
    check("R10 release", dtack_n, 1);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_unconfigured();
    t_word_rw();
    t_lanes();
    t_outside();
    t_signature();
    t_video();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #500000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule